// File: doc/BRIEF.md
# Reference Release Decision Unit

This unit handles the release of one object reference in a reference-counted heap. It is given a reference. It reads the 16-bit header word that sits two words below the reference and lowers the packed reference count in that word. From the header flags it then chooses one of the following outcomes:

- leave the object alone;
- ask the zero-count table to record the object;
- hand the object back for reclaiming;
- raise a trap.

An object whose count reaches zero may still be named from a stack. For such an object the unit hashes its header address and looks it up in an external residue table. A table entry that matches the object's residue, or that holds the wildcard value, keeps the object alive.

A single-word memory port with a one-cycle read latency carries all traffic: the header read, the residue table read and the header write-back. When the unit finishes it pulses `doneValid` for one cycle. In that same cycle it presents the result code, any trap code, the header write, and, when the object must be recorded, an append request carrying the header address. The unit does not perform the append itself.

Top module: `rc_release_unit`

## Requirements
- R1: A reference with bit 0 set is accepted and finishes one cycle later. It finishes with trap code 5, result 0, no memory read and no memory write.
- R2: The header word has these fields, counted from the least significant bit:
  - bit 15: in-table flag;
  - bit 14: maybe-on-stack flag;
  - bits 13..8: size class;
  - bit 7: finalize flag;
  - bits 6..1: count;
  - bit 0: overflow flag.

  When the count is above 1, the header minus 2 is written back to reference−2 and the result is 0 (continue). No trap and no append are raised, and the unit finishes 4 cycles after acceptance.
- R3: When the count is 0 and the overflow flag is clear, the unit raises trap code 5 and writes nothing.
- R4: When the count is 0 and the overflow flag is set, the unit raises trap code 3 and writes nothing.
- R5: When the count is 1 and the overflow flag is set, the header minus 2 is written back and the result is 0. No append is raised.
- R6: When the count is 1, the overflow flag is clear and the in-table flag is set, the header minus 2 is written back and the result is 0. No append and no table read take place, so the unit finishes in 4 cycles.
- R7: When the count is 1, the overflow and in-table flags are clear and the maybe-on-stack flag is set, the header is written back and the result is 0. An append carrying reference−2 is raised, and the unit finishes in 4 cycles.
- R8: In every other count-1 case the unit reads the residue table and finishes 7 cycles after acceptance. Let N be reference−2. The residue R is bits 21..13 of N. The table is read at TABLE_BASE + (N[12:1] XOR R).
- R9: When the table word equals R zero-extended to 16 bits, or equals 16'hFFFF, the header is written back, an append of N is raised and the result is 0.
- R10: When the table misses and the finalize flag is 0, the header is written back and the result is 1 (reclaim). No append is raised.
- R11: When the table misses and the finalize flag is 1, the unit raises trap code 6 with result 2 (finalize) and writes nothing.
- R12: `reqReady` is low from acceptance until completion. A request offered during that time is ignored.
- R13: After reset, `reqReady` is high and `doneValid`, `memRdEn` and `memWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqRef | input | 22 | Reference to release |
| reqReady | output | 1 | Unit idle, request will be taken |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 22 | Memory word address |
| memWrData | output | 16 | Header value to write |
| memRdData | input | 16 | Read data, valid the cycle after `memRdEn` |
| doneValid | output | 1 | One-cycle completion pulse |
| resultCode | output | 2 | 0 continue, 1 reclaim, 2 finalize |
| trapValid | output | 1 | A trap is raised with this completion |
| trapCode | output | 3 | Trap code 3, 5 or 6 |
| appendValid | output | 1 | Request to record the header address in the zero-count table |
| appendNhp | output | 22 | Header address, reference−2 |

## Verification
All results appear together in the single cycle in which `doneValid` is high, and that cycle is fixed by the path taken. Latency is counted in rising edges after the edge that accepts the request:

- an odd reference completes after 1 edge;
- every header-only decision completes after 4 edges (read, wait, capture, decide);
- every decision that consults the residue table completes after 7 edges.

The bench counts edges from acceptance to `doneValid` and compares that count with the figure for the path. It samples the write, append, result and trap outputs on the falling edge inside the completion cycle. The memory model keeps a record of the last table address read, so the hashed address can be checked after completion.

// File: rtl/rc_release_pkg.sv
package rc_release_pkg;

  // Header bit positions, LSB numbering
  localparam int HDR_IN_TABLE = 15;
  localparam int HDR_ON_STACK = 14;
  localparam int HDR_FINAL    = 7;
  localparam int HDR_CNT_LO   = 1;
  localparam int HDR_CNT_W    = 6;
  localparam int HDR_OVF      = 0;

  localparam logic [2:0] TRAP_UNDERFLOW = 3'd3;
  localparam logic [2:0] TRAP_BUG       = 3'd5;
  localparam logic [2:0] TRAP_FINALIZE  = 3'd6;

  localparam logic [15:0] RESIDUE_WILDCARD = 16'hFFFF;

  typedef enum logic [1:0] {
    RES_CONTINUE = 2'd0,
    RES_RECLAIM  = 2'd1,
    RES_FINALIZE = 2'd2
  } rcResult_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadRef;
    logic loadHdr;
    logic loadEntry;
    logic rdHdr;
    logic rdTbl;
    logic wrHdr;
  } rcStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic cntHigh;
    logic cntZero;
    logic ovf;
    logic inTable;
    logic onStack;
    logic finFlag;
    logic tblHit;
  } rcStatus_t;

endpackage

// File: rtl/rc_release_dp.sv
module rc_release_dp
  import rc_release_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int IDX_W = 12,
  parameter int unsigned TABLE_BASE = 'h3F0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqRef,
  input  logic [15:0]       memRdData,
  output logic              refOdd,
  output rcStatus_t         status,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic [ADDR_W-1:0] nhp
);

  localparam int RES_W = ADDR_W - IDX_W - 1;

  logic [ADDR_W-1:0] refReg;
  logic [15:0]       hdrReg;
  logic [15:0]       entryReg;
  logic [RES_W-1:0]  residue;
  logic [IDX_W-1:0]  tblIdx;
  logic [ADDR_W-1:0] tblAddr;
  logic [HDR_CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refReg   <= '0;
      hdrReg   <= '0;
      entryReg <= '0;
    end else begin
      if (strobe.loadRef)   refReg   <= reqRef;
      if (strobe.loadHdr)   hdrReg   <= memRdData;
      if (strobe.loadEntry) entryReg <= memRdData;
    end
  end

  assign refOdd = reqRef[0];
  assign nhp    = refReg - ADDR_W'(2);

  // Hash: residue from top bits, folded into the word index above bit 0
  assign residue = nhp[ADDR_W-1 -: RES_W];
  assign tblIdx  = nhp[IDX_W:1] ^ IDX_W'(residue);
  assign tblAddr = ADDR_W'(TABLE_BASE) + ADDR_W'(tblIdx);

  assign cnt = hdrReg[HDR_CNT_LO +: HDR_CNT_W];

  always_comb begin
    status.cntHigh = cnt > HDR_CNT_W'(1);
    status.cntZero = cnt == '0;
    status.ovf     = hdrReg[HDR_OVF];
    status.inTable = hdrReg[HDR_IN_TABLE];
    status.onStack = hdrReg[HDR_ON_STACK];
    status.finFlag = hdrReg[HDR_FINAL];
    status.tblHit  = (entryReg == 16'(residue)) || (entryReg == RESIDUE_WILDCARD);
  end

  assign memAddr   = strobe.rdTbl ? tblAddr : nhp;
  assign memWrData = hdrReg - 16'd2;

endmodule

// File: rtl/rc_release_ctl.sv
module rc_release_ctl
  import rc_release_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       refOdd,
  input  rcStatus_t  status,
  output rcStrobe_t  strobe,
  output logic       reqReady,
  output logic       doneValid,
  output logic [1:0] resultCode,
  output logic       trapValid,
  output logic [2:0] trapCode,
  output logic       appendValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR_RD, ST_HDR_WAIT, ST_DECIDE,
    ST_TBL_RD, ST_TBL_WAIT, ST_RESOLVE, ST_FINISH
  } rcState_e;

  rcState_e  state, stateNext;
  logic      wrFlag, appFlag, trapFlag;
  logic [2:0] codeReg;
  rcResult_e resReg;

  logic      decLoad, decWr, decApp, decTrap;
  logic [2:0] decCode;
  rcResult_e decRes;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    decLoad   = 1'b0;
    decWr     = 1'b0;
    decApp    = 1'b0;
    decTrap   = 1'b0;
    decCode   = 3'd0;
    decRes    = RES_CONTINUE;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadRef = 1'b1;
          decLoad = 1'b1;
          if (refOdd) begin
            decTrap   = 1'b1;
            decCode   = TRAP_BUG;
            stateNext = ST_FINISH;
          end else begin
            stateNext = ST_HDR_RD;
          end
        end
      end
      ST_HDR_RD: begin
        strobe.rdHdr = 1'b1;
        stateNext = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: begin
        strobe.loadHdr = 1'b1;
        stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (status.cntZero) begin
          decLoad   = 1'b1;
          decTrap   = 1'b1;
          decCode   = status.ovf ? TRAP_UNDERFLOW : TRAP_BUG;
          stateNext = ST_FINISH;
        end else if (status.cntHigh || status.ovf || status.inTable) begin
          decLoad   = 1'b1;
          decWr     = 1'b1;
          stateNext = ST_FINISH;
        end else if (status.onStack) begin
          decLoad   = 1'b1;
          decWr     = 1'b1;
          decApp    = 1'b1;
          stateNext = ST_FINISH;
        end else begin
          stateNext = ST_TBL_RD;
        end
      end
      ST_TBL_RD: begin
        strobe.rdTbl = 1'b1;
        stateNext = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        strobe.loadEntry = 1'b1;
        stateNext = ST_RESOLVE;
      end
      ST_RESOLVE: begin
        decLoad = 1'b1;
        if (status.tblHit) begin
          decWr  = 1'b1;
          decApp = 1'b1;
        end else if (!status.finFlag) begin
          decWr  = 1'b1;
          decRes = RES_RECLAIM;
        end else begin
          decTrap = 1'b1;
          decCode = TRAP_FINALIZE;
          decRes  = RES_FINALIZE;
        end
        stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        strobe.wrHdr = wrFlag;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wrFlag   <= 1'b0;
      appFlag  <= 1'b0;
      trapFlag <= 1'b0;
      codeReg  <= 3'd0;
      resReg   <= RES_CONTINUE;
    end else begin
      state <= stateNext;
      if (decLoad) begin
        wrFlag   <= decWr;
        appFlag  <= decApp;
        trapFlag <= decTrap;
        codeReg  <= decCode;
        resReg   <= decRes;
      end
    end
  end

  assign reqReady    = state == ST_IDLE;
  assign doneValid   = state == ST_FINISH;
  assign resultCode  = doneValid ? resReg : RES_CONTINUE;
  assign trapValid   = doneValid & trapFlag;
  assign trapCode    = doneValid ? codeReg : 3'd0;
  assign appendValid = doneValid & appFlag;

endmodule

// File: rtl/rc_release_unit.sv
module rc_release_unit
  import rc_release_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int IDX_W = 12,
  parameter int unsigned TABLE_BASE = 'h3F0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqRef,
  output logic              reqReady,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  input  logic [15:0]       memRdData,
  output logic              doneValid,
  output logic [1:0]        resultCode,
  output logic              trapValid,
  output logic [2:0]        trapCode,
  output logic              appendValid,
  output logic [ADDR_W-1:0] appendNhp
);

  rcStrobe_t strobe;
  rcStatus_t status;
  logic      refOdd;

  rc_release_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .refOdd(refOdd),
    .status(status), .strobe(strobe), .reqReady(reqReady),
    .doneValid(doneValid), .resultCode(resultCode), .trapValid(trapValid),
    .trapCode(trapCode), .appendValid(appendValid)
  );

  rc_release_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TABLE_BASE(TABLE_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRef(reqRef),
    .memRdData(memRdData), .refOdd(refOdd), .status(status),
    .memAddr(memAddr), .memWrData(memWrData), .nhp(appendNhp)
  );

  assign memRdEn = strobe.rdHdr | strobe.rdTbl;
  assign memWrEn = strobe.wrHdr;

endmodule

// File: rtl/rc_release_chk.sv
module rc_release_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       refLsb,
  input logic       reqReady,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic       doneValid,
  input logic [1:0] resultCode,
  input logic       trapValid,
  input logic [2:0] trapCode,
  input logic       appendValid
);

  AST_ODD_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && refLsb |=> doneValid && trapValid && trapCode == 3'd5); // R1

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && trapValid |-> !memWrEn && !appendValid); // R3

  AST_FINAL_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && resultCode == 2'd2 |-> trapValid && trapCode == 3'd6); // R11

  AST_APPEND_CONT: assert property (@(posedge clk) disable iff (!rstN)
    appendValid |-> doneValid && memWrEn && resultCode == 2'd0); // R7

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn || memWrEn |-> !reqReady); // R12

endmodule

bind rc_release_unit rc_release_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .refLsb(reqRef[0]),
  .reqReady(reqReady), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .doneValid(doneValid), .resultCode(resultCode), .trapValid(trapValid),
  .trapCode(trapCode), .appendValid(appendValid)
);

// File: tb/rc_release_unit_bench.sv
`timescale 1ns/1ps
module rc_release_unit_bench;

  localparam int unsigned TBL_BASE = 'h3F0000;

  typedef struct packed {
    logic [21:0] refv;
    logic [15:0] hdr;
    logic [1:0]  entSel;   // 0: residue, 1: wildcard, 2: miss
    logic [3:0]  lat;
    logic        wr;
    logic [15:0] wrData;
    logic        app;
    logic [1:0]  res;
    logic        trap;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{22'h012346, 16'h0506, 2'd0, 4'd4, 1'b1, 16'h0504, 1'b0, 2'd0, 1'b0, 3'd0},
    '{22'h020010, 16'h0700, 2'd0, 4'd4, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd5},
    '{22'h030020, 16'h0701, 2'd0, 4'd4, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd3},
    '{22'h040032, 16'h0203, 2'd0, 4'd4, 1'b1, 16'h0201, 1'b0, 2'd0, 1'b0, 3'd0},
    '{22'h050044, 16'h8202, 2'd0, 4'd4, 1'b1, 16'h8200, 1'b0, 2'd0, 1'b0, 3'd0},
    '{22'h060056, 16'h4202, 2'd0, 4'd4, 1'b1, 16'h4200, 1'b1, 2'd0, 1'b0, 3'd0},
    '{22'h1ABCDE, 16'h0302, 2'd0, 4'd7, 1'b1, 16'h0300, 1'b1, 2'd0, 1'b0, 3'd0},
    '{22'h2468AC, 16'h0302, 2'd1, 4'd7, 1'b1, 16'h0300, 1'b1, 2'd0, 1'b0, 3'd0},
    '{22'h13579A, 16'h0302, 2'd2, 4'd7, 1'b1, 16'h0300, 1'b0, 2'd1, 1'b0, 3'd0},
    '{22'h2FEDC8, 16'h0382, 2'd2, 4'd7, 1'b0, 16'h0000, 1'b0, 2'd2, 1'b1, 3'd6},
    '{22'h070068, 16'hC3FE, 2'd0, 4'd4, 1'b1, 16'hC3FC, 1'b0, 2'd0, 1'b0, 3'd0},
    '{22'h08007A, 16'h0241, 2'd0, 4'd4, 1'b1, 16'h023F, 1'b0, 2'd0, 1'b0, 3'd0}
  };
  localparam string TAGS [NV] = '{"R2", "R3", "R4", "R5", "R6", "R7",
                                  "R9", "R9", "R10", "R11", "R2", "R2"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [21:0] reqRef = '0;
  logic        reqReady, memRdEn, memWrEn, doneValid, trapValid, appendValid;
  logic [21:0] memAddr, appendNhp;
  logic [15:0] memWrData;
  logic [15:0] memRdData = '0;
  logic [1:0]  resultCode;
  logic [2:0]  trapCode;

  int total = 0;
  int bad = 0;
  int rdCount = 0;
  logic [21:0] tblSeen = '0;
  logic [21:0] curRef = '0;
  logic [15:0] curHdr = '0;
  logic [1:0]  curSel = '0;

  always #5 clk = ~clk;

  rc_release_unit #(.TABLE_BASE(TBL_BASE)) u_rc_release_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRef(reqRef),
    .reqReady(reqReady), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .doneValid(doneValid), .resultCode(resultCode), .trapValid(trapValid),
    .trapCode(trapCode), .appendValid(appendValid), .appendNhp(appendNhp)
  );

  function automatic logic [8:0] residueOf(input logic [21:0] r);
    logic [21:0] n = r - 22'd2;
    return n[21:13];
  endfunction

  function automatic logic [21:0] tblAddrOf(input logic [21:0] r);
    logic [21:0] n = r - 22'd2;
    logic [11:0] idx = n[12:1] ^ {3'b000, n[21:13]};
    return 22'(TBL_BASE) + {10'd0, idx};
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) begin
      rdCount <= rdCount + 1;
      if (memAddr >= 22'(TBL_BASE)) begin
        tblSeen <= memAddr;
        if (memAddr != tblAddrOf(curRef)) memRdData <= 16'h8000;
        else if (curSel == 2'd0) memRdData <= {7'd0, residueOf(curRef)};
        else if (curSel == 2'd1) memRdData <= 16'hFFFF;
        else memRdData <= {7'd0, residueOf(curRef) ^ 9'd1};
      end else begin
        memRdData <= (memAddr == curRef - 22'd2) ? curHdr : 16'hDEAD;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Offer a request at a negedge; return edges to completion
  task automatic launch(input logic [21:0] r, output int lat);
    curRef = r;
    @(negedge clk);
    reqValid = 1'b1;
    reqRef = r;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!doneValid && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runVec(input vec_t v, input string tag);
    int lat;
    curHdr = v.hdr;
    curSel = v.entSel;
    launch(v.refv, lat);
    chk(tag, "latency", lat, {28'd0, v.lat});
    chk(tag, "memWrEn", {31'd0, memWrEn}, {31'd0, v.wr});
    if (v.wr) begin
      chk(tag, "wrData", {16'd0, memWrData}, {16'd0, v.wrData});
      chk(tag, "wrAddr", {10'd0, memAddr}, {10'd0, v.refv - 22'd2});
    end
    chk(tag, "append", {31'd0, appendValid}, {31'd0, v.app});
    if (v.app) chk(tag, "appendNhp", {10'd0, appendNhp}, {10'd0, v.refv - 22'd2});
    chk(tag, "result", {30'd0, resultCode}, {30'd0, v.res});
    chk(tag, "trap", {31'd0, trapValid}, {31'd0, v.trap});
    if (v.trap) chk(tag, "trapCode", {29'd0, trapCode}, {29'd0, v.code});
    // R8: hashed table address for every table-consulting path
    if (v.lat == 4'd7) chk("R8", "tblAddr", {10'd0, tblSeen}, {10'd0, tblAddrOf(v.refv)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    int rd0;
    int doneSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: idle state after reset
    chk("R13", "reqReady", {31'd0, reqReady}, 32'd1);
    chk("R13", "doneValid", {31'd0, doneValid}, 32'd0);
    chk("R13", "memRdEn", {31'd0, memRdEn}, 32'd0);
    chk("R13", "memWrEn", {31'd0, memWrEn}, 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], TAGS[i]);

    // R1: odd reference
    rd0 = rdCount;
    launch(22'h012345, lat);
    chk("R1", "latency", lat, 32'd1);
    chk("R1", "trap", {31'd0, trapValid}, 32'd1);
    chk("R1", "trapCode", {29'd0, trapCode}, 32'd5);
    chk("R1", "memWrEn", {31'd0, memWrEn}, 32'd0);
    chk("R1", "result", {30'd0, resultCode}, 32'd0);
    @(negedge clk);
    chk("R1", "reads", rdCount, rd0);

    // R12: request while busy is ignored
    curHdr = 16'h0506;
    curRef = 22'h012346;
    reqValid = 1'b1;
    reqRef = 22'h012346;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "reqReady busy", {31'd0, reqReady}, 32'd0);
    reqRef = 22'h000101;
    lat = 1;
    while (!doneValid && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    chk("R12", "latency", lat, 32'd4);
    chk("R12", "trap", {31'd0, trapValid}, 32'd0);
    chk("R12", "wrData", {16'd0, memWrData}, 32'h0504);
    doneSeen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (doneValid) doneSeen++;
    end
    chk("R12", "no extra completion", doneSeen, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule